// File: doc/BRIEF.md
# Reaction Time Measurement Core

This block times how quickly a person answers a visual stimulus. A go trigger from the surrounding timing logic lights the stimulus lamp and starts a decimal millisecond counter. The counter advances once per 1 ms tick. When the person presses the stop button, the lamp goes dark and the count freezes. The frozen value is the reaction time in milliseconds, held as four BCD digits that an external seven-segment decoder can display directly.

The start button acts as a clear. It returns the block to its waiting state with all digits at zero, ready for the next go trigger. A stop press before the lamp has lit is ignored. A run that is never stopped saturates at the largest count the digits can show, so the display never wraps to a small false value. The stop button arrives already debounced. The block detects its rising edge on the system clock, so a button that is held down stops nothing until it is released and pressed again.

Top module: `reaction_core`

## Requirements
- R1: After the synchronous reset, the lamp output is low and every digit reads zero.
- R2: While waiting (lamp off, digits zero), a high go input turns the lamp on in the next cycle, and counting begins with the ticks that follow.
- R3: While the lamp is on, the count rises by exactly one on each cycle with the tick input high, and stays put on cycles without a tick.
- R4: The digits are 4-bit BCD nibbles, with the least significant (milliseconds) digit in bits 3:0. Each digit goes from 9 to 0 and carries one into the next higher digit, so 0009 becomes 0010 and 0999 becomes 1000.
- R5: A rising edge on the stop input while the lamp is on turns the lamp off in the next cycle. It freezes the digits at the value they hold on the cycle the edge is seen, and a tick on that same cycle is not counted.
- R6: Only a low-to-high change of the stop input counts as a press. A stop input that is already high when the lamp lights does not stop the run; the run stops only when the input goes low and then high again.
- R7: A stop press while waiting is ignored: the lamp stays off, the digits stay zero, and a later go still starts a normal run.
- R8: Once stopped, the frozen digits and the dark lamp are unaffected by ticks, go, or further stop presses until a clear.
- R9: A clear returns the block to waiting, with the lamp off and digits zero, from any state. When clear and go are high in the same cycle, clear wins.
- R10: At 9999 the count saturates instead of wrapping. The lamp stays on and the digits hold 9999 until stop or clear.
- R11: A go input while the lamp is on neither restarts nor alters the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| go | input | 1 | Stimulus trigger that lights the lamp |
| stop_btn | input | 1 | Debounced stop button level, active high |
| clear | input | 1 | Start-button clear, returns to waiting |
| lamp_on | output | 1 | Stimulus lamp enable |
| digits | output | 16 | Four BCD digits of elapsed milliseconds, units in bits 3:0 |

## Verification
The hardest situation to reach from the ports is saturation. It needs ten thousand ticks inside a single run, without a stop edge, before the hold at 9999 shows. The stimulus asserts the tick on every cycle of one long run. This passes through every carry boundary up to 9999, then keeps ticking past it before a final stop. A second awkward case is a stop input that is already high when the lamp lights. The bench raises stop while the block is waiting, keeps it high across go, and releases and presses it again before expecting the freeze.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int BCD_W = 4;
    localparam logic [BCD_W-1:0] BCD_TOP = 4'd9;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rt_state_e;

    typedef struct packed {
        logic lamp;
        logic count_en;
    } rt_ctrl_t;

    function automatic bcd_t bcd_next(input bcd_t d);
        return (d == BCD_TOP) ? '0 : bcd_t'(d + 1'b1);
    endfunction

    function automatic logic bcd_is_top(input bcd_t d);
        return d == BCD_TOP;
    endfunction

endpackage

// File: rtl/rt_stop_edge.sv
module rt_stop_edge (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    logic btn_q;

    always_ff @(posedge clk) begin
        if (rst) btn_q <= 1'b0;
        else     btn_q <= btn;
    end

    assign press = btn & ~btn_q;
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
    import rt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     go,
    input  logic     press,
    input  logic     tick,
    output rt_ctrl_t ctl
);
    rt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go)    state_d = ST_RUN;
                ST_RUN:  if (press) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        ctl.lamp     = (state_q == ST_RUN);
        ctl.count_en = (state_q == ST_RUN) && tick && !press && !clear;
    end
endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter
    import rt_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   en,
    output bcd_t [NUM_DIGITS-1:0]  dig
);
    bcd_t [NUM_DIGITS-1:0] dig_q;
    logic [NUM_DIGITS-1:0] top_mask;
    logic [NUM_DIGITS-1:0] carry;
    logic                  all_top;

    assign all_top  = &top_mask;
    assign carry[0] = en & ~all_top;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        assign top_mask[g] = bcd_is_top(dig_q[g]);

        if (g < NUM_DIGITS - 1) begin : g_carry
            assign carry[g+1] = carry[g] & top_mask[g];
        end

        always_ff @(posedge clk) begin
            if (rst || clear)  dig_q[g] <= '0;
            else if (carry[g]) dig_q[g] <= bcd_next(dig_q[g]);
        end
    end

    assign dig = dig_q;
endmodule

// File: rtl/reaction_core.sv
module reaction_core
    import rt_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int DIG_BITS  = NUM_DIGITS * BCD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_ms,
    input  logic                go,
    input  logic                stop_btn,
    input  logic                clear,
    output logic                lamp_on,
    output logic [DIG_BITS-1:0] digits
);
    logic                  stop_press;
    rt_ctrl_t              ctl;
    bcd_t [NUM_DIGITS-1:0] cnt;

    rt_stop_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .btn   (stop_btn),
        .press (stop_press)
    );

    rt_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .go    (go),
        .press (stop_press),
        .tick  (tick_ms),
        .ctl   (ctl)
    );

    rt_bcd_counter #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .en    (ctl.count_en),
        .dig   (cnt)
    );

    assign lamp_on = ctl.lamp;
    assign digits  = cnt;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int NUM_DIGITS = 4,
    localparam int DIG_BITS  = NUM_DIGITS * 4
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_ms,
    input logic                go,
    input logic                clear,
    input logic                stop_press,
    input logic                lamp_on,
    input logic [DIG_BITS-1:0] digits
);
    logic all_nine;
    logic all_valid;

    always_comb begin
        all_nine  = 1'b1;
        all_valid = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (digits[i*4 +: 4] != 4'd9) all_nine  = 1'b0;
            if (digits[i*4 +: 4] >  4'd9) all_valid = 1'b0;
        end
    end

    AST_LAMP_FROM_GO: assert property (@(posedge clk) disable iff (rst)
        $rose(lamp_on) |-> $past(go)); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (lamp_on && !tick_ms && !clear) |=> $stable(digits)); // R3
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
        all_valid); // R4
    AST_STOP_DARKENS: assert property (@(posedge clk) disable iff (rst)
        (lamp_on && stop_press && !clear) |=> (!lamp_on && $stable(digits))); // R5
    AST_DARK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!lamp_on && !clear) |=> $stable(digits)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (digits == '0 && !lamp_on)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (lamp_on && all_nine && !clear && !stop_press) |=> (lamp_on && all_nine)); // R10
endmodule

bind reaction_core rt_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_ms    (tick_ms),
    .go         (go),
    .clear      (clear),
    .stop_press (stop_press),
    .lamp_on    (lamp_on),
    .digits     (digits)
);

// File: tb/tb_reaction_core.sv
module tb_reaction_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic        go = 1'b0;
    logic        stop_btn = 1'b0;
    logic        clear = 1'b0;
    logic        lamp_on;
    logic [15:0] digits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    reaction_core dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .go(go),
        .stop_btn(stop_btn), .clear(clear), .lamp_on(lamp_on), .digits(digits)
    );

    // scoreboard queues
    logic        q_lamp[$];
    logic [15:0] q_dig[$];
    string       q_tag[$];

    // requirement-level model state
    int   m_st = 0;
    int   m_cnt = 0;
    logic m_prev = 1'b0;

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic step(input logic r, input logic g, input logic s,
                        input logic c, input logic t, input string tag);
        logic press;
        @(negedge clk);
        rst = r; go = g; stop_btn = s; clear = c; tick_ms = t;
        press = s && !m_prev;
        if (r) begin
            m_st = 0; m_cnt = 0; m_prev = 1'b0;
        end else begin
            if (c) begin
                m_st = 0; m_cnt = 0;
            end else begin
                case (m_st)
                    0: if (g) m_st = 1;
                    1: if (press) m_st = 2;
                       else if (t && m_cnt < 9999) m_cnt++;
                    default: ;
                endcase
            end
            m_prev = s;
        end
        q_lamp.push_back(m_st == 1);
        q_dig.push_back(to_bcd(m_cnt));
        q_tag.push_back(tag);
    endtask

    task automatic ticks(input int n, input logic s, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, s, 0, 1, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_lamp.size() > 0) begin
                logic        el;
                logic [15:0] ed;
                string       et;
                el = q_lamp.pop_front();
                ed = q_dig.pop_front();
                et = q_tag.pop_front();
                checks++;
                if (lamp_on !== el || digits !== ed) begin
                    failures++;
                    $display("FAIL %s: lamp=%b digits=%h expected lamp=%b digits=%h",
                             et, lamp_on, digits, el, ed);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, "R1 reset");
        step(0, 0, 0, 0, 0, "R1 after reset");
        ticks(3, 0, "R8 idle ticks hold zero");
        // R7: stop press while waiting
        step(0, 0, 1, 0, 1, "R7 stop in idle");
        step(0, 0, 0, 0, 1, "R7 stop released");
        // R2: go lights lamp
        step(0, 1, 0, 0, 0, "R2 go");
        step(0, 0, 0, 0, 0, "R2 lamp on no tick");
        // R3: ticks interleaved with idle cycles
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 0, 0, 1, "R3 tick");
            step(0, 0, 0, 0, 0, "R3 no tick");
        end
        ticks(6, 0, "R4 wrap to 0012");
        // R11: go during run
        step(0, 1, 0, 0, 1, "R11 go in run");
        // R5: stop with tick on same cycle
        step(0, 0, 1, 0, 1, "R5 stop freezes");
        step(0, 0, 1, 0, 1, "R5 lamp off");
        // R8: done ignores stimulus
        step(0, 0, 0, 0, 1, "R8 done tick");
        step(0, 1, 1, 0, 1, "R8 done go and stop");
        ticks(3, 0, "R8 done holds");
        // R9: clear, then clear beats go
        step(0, 0, 0, 1, 0, "R9 clear from done");
        step(0, 1, 0, 1, 0, "R9 clear wins over go");
        step(0, 0, 0, 0, 1, "R9 still waiting");
        // R6: stop held across go
        step(0, 0, 1, 0, 0, "R6 stop raised while waiting");
        step(0, 1, 1, 0, 0, "R6 go with stop held");
        ticks(5, 1, "R6 held stop does not stop");
        step(0, 0, 0, 0, 1, "R6 released");
        step(0, 0, 1, 0, 0, "R6 repress stops");
        step(0, 0, 1, 0, 1, "R6 frozen");
        // R9: clear during run
        step(0, 0, 0, 1, 0, "R9 clear");
        step(0, 1, 0, 0, 0, "R9 go");
        ticks(4, 0, "R9 run");
        step(0, 0, 0, 1, 1, "R9 clear during run");
        // R10: saturation
        step(0, 1, 0, 0, 0, "R10 go long run");
        ticks(998, 0, "R4 approach 0999");
        ticks(2, 0, "R4 carry to 1000");
        ticks(9005, 0, "R10 saturate at 9999");
        step(0, 0, 0, 0, 0, "R10 lamp stays on");
        step(0, 0, 1, 0, 1, "R10 stop at 9999");
        step(0, 0, 0, 0, 1, "R10 frozen 9999");
        step(0, 0, 0, 1, 0, "R9 final clear");
        step(0, 0, 0, 0, 0, "R9 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule